// File: doc/BRIEF.md
# LCD Frame Fetch Sequencer

This block prepares each refresh of an LCD controller whose frame buffers begin with a palette header. On every refresh request it reads the first 16-bit word of the active frame buffer and takes the pixel depth from that word. It then works out where the pixel data begins and checks that the whole frame fits between the active buffer's top and bottom pointers. If the frame fits, it hands a pixel start address, a per-line byte stride, a pixel depth and a line window to the pixel fetch engine. After that it reports the buffer as done toward the DMA status register and, in dual-buffer mode, moves to the other buffer.

The sequencer also owns the controller enable. When enable changes from 0 to 1, every buffer pointer in use is compared against a legal address window. A pointer outside that window refuses the start and reports an address fault. A frame that does not fit raises a sync error and turns the controller off. Pixel conversion and the memory fabric are handled elsewhere. The header read uses a simple request/valid pair.

Top module: `lcdf_seq`

## Requirements
- R1: Bits 14:12 of the header word give the depth code. Code 1 gives `pix_bits`=2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16.
- R2: A header with depth code 0 produces no `frame_go`, no `sync_err` and no `cond_set` bit, and the block returns to idle.
- R3: With `pal_mode` other than 2, pixel data starts 0x200 bytes after the buffer base for codes 3 to 7 and 0x20 bytes after it for codes 1 and 2. With `pal_mode`=2 no header is read, the offset is 0, and the most recently read header word is used (0 after reset).
- R4: A refresh is ignored when the controller is disabled or `pal_mode`=1: no `hdr_req` and no `frame_go`.
- R5: The size is the active buffer's bottom pointer minus its top pointer. If offset + width×height×bpp/8 exceeds size+2, `sync_err` pulses, `lcd_enable` drops and no `frame_go` is produced. A frame that needs exactly size+2 bytes is accepted.
- R6: For a good frame, `frame_go` pulses for one cycle with `pix_addr` = latched base of the active buffer + offset. In the next cycle `cond_set` bit N pulses, where N is the buffer index (0 or 1). `dma_irq` pulses together with it when `dma_ie[0]` is 1.
- R7: With `dual_buf`=1 the buffer index toggles after each good frame. With `dual_buf`=0 it stays at 0.
- R8: `line_stride` = width×bpp/8 bytes, with width = `width_m1`+1.
- R9: With `sub_en`=0, `line_first`=0 and `line_total`=height. With `sub_en`=1 and `sub_first_sel`=1, `line_first`=`sub_val` and `line_total` is unchanged. With `sub_en`=1 and `sub_first_sel`=0, `line_total`=`sub_val` and `line_first`=0.
- R10: On an enable 0→1 write, if buffer 0's pointers, or (when `dual_buf`=1) buffer 1's pointers, lie outside [`win_lo`,`win_hi`], then `cond_set[2]` pulses one cycle later, `dma_irq` pulses with it if `dma_ie[1]` is 1, and `lcd_enable` stays 0. Buffer 1's pointers are not checked in single mode.
- R11: A successful enable start sets the buffer index to 0 and latches both bases from the top pointers. Later changes of the top inputs do not move `pix_addr`. Writing 1 while already enabled has no effect.
- R12: While a header read is pending, `hdr_req` stays high with `hdr_addr` equal to the active base until `hdr_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable value written |
| pal_mode | input | 2 | Palette load mode |
| dual_buf | input | 1 | Ping-pong between two buffers |
| dma_ie | input | 2 | Bit 0: frame-done interrupt, bit 1: address fault interrupt |
| buf0_top | input | AW | Buffer 0 start pointer |
| buf0_bot | input | AW | Buffer 0 end pointer |
| buf1_top | input | AW | Buffer 1 start pointer |
| buf1_bot | input | AW | Buffer 1 end pointer |
| win_lo | input | AW | Lowest legal address |
| win_hi | input | AW | Highest legal address |
| width_m1 | input | DIM_W | Pixels per line minus one |
| height_m1 | input | DIM_W | Lines per frame minus one |
| sub_en | input | 1 | Sub-panel override on |
| sub_first_sel | input | 1 | Override sets first line (1) or line total (0) |
| sub_val | input | DIM_W | Sub-panel line value |
| refresh | input | 1 | Start-of-refresh pulse |
| hdr_req | output | 1 | Header read request |
| hdr_addr | output | AW | Header read address |
| hdr_valid | input | 1 | Header data valid |
| hdr_data | input | 16 | Header word |
| lcd_enable | output | 1 | Controller enabled |
| busy | output | 1 | Sequencer not idle |
| frame_go | output | 1 | Frame parameters valid (one cycle) |
| pix_addr | output | AW | First pixel byte address |
| line_stride | output | DIM_W+2 | Bytes per line |
| pix_bits | output | 5 | Bits per pixel |
| line_first | output | DIM_W | First line shown |
| line_total | output | DIM_W+1 | Line count |
| cond_set | output | 3 | DMA condition set pulses (bit 0/1 buffer done, bit 2 address fault) |
| dma_irq | output | 1 | DMA interrupt pulse |
| sync_err | output | 1 | Frame overflow pulse |

## Verification
The hardest case to reach is the second buffer's frame after an enable rewrite. To get there, the controller must start cleanly in dual mode, complete one good frame so the index moves to 1, and then receive another enable write of 1. Only the pixel address of the following frame shows that the index was kept. The bench also moves a bottom pointer by one byte around the size+2 limit, and it changes a top pointer after start-up so that any live use of that input is exposed.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_HDR,
      ST_CHECK,
      ST_ISSUE,
      ST_DONE
   } seq_state_e;

   // log2 of bits per pixel for a depth code; 0 means unsupported
   function automatic logic [2:0] depth_lg(input logic [2:0] code);
      logic [2:0] r;
      case (code)
         3'd0:    r = 3'd0;
         3'd1:    r = 3'd1;
         3'd2:    r = 3'd2;
         3'd3:    r = 3'd3;
         default: r = 3'd4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lcdf_hdr_decode.sv
module lcdf_hdr_decode
   import lcdf_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LONG_OFS  = 'h200,
   parameter int SHORT_OFS = 'h20,
   parameter int CODE_LSB  = 12
) (
   input  logic [15:0]   hdr,
   input  logic          no_hdr,
   output logic          supported,
   output logic [2:0]    lg_bpp,
   output logic [4:0]    pix_bits,
   output logic [AW-1:0] data_ofs
);
   localparam int CODE_W = 3;

   logic [CODE_W-1:0] code;

   initial begin
      assert (CODE_LSB + CODE_W <= 16) else $error("depth field outside header word");
      assert (LONG_OFS > SHORT_OFS) else $error("offset ordering");
   end

   assign code      = hdr[CODE_LSB +: CODE_W];
   assign lg_bpp    = depth_lg(code);
   assign supported = (lg_bpp != 3'd0);
   assign pix_bits  = 5'd1 << lg_bpp;

   always_comb begin
      if (no_hdr)
         data_ofs = '0;
      else if (code >= 3'd3)
         data_ofs = AW'(LONG_OFS);
      else
         data_ofs = AW'(SHORT_OFS);
   end

endmodule

// File: rtl/lcdf_win_check.sv
module lcdf_win_check #(
   parameter int AW = 32,
   parameter int NB = 4
) (
   input  logic [NB*AW-1:0] bounds,
   input  logic [NB-1:0]    use_mask,
   input  logic [AW-1:0]    win_lo,
   input  logic [AW-1:0]    win_hi,
   output logic             all_ok
);
   logic [NB-1:0] ok_vec;

   initial begin
      assert (NB >= 1) else $error("need at least one bound");
   end

   genvar g;
   generate
      for (g = 0; g < NB; g++) begin : g_bound
         logic [AW-1:0] a;
         assign a = bounds[g*AW +: AW];
         assign ok_vec[g] = !use_mask[g] || ((a >= win_lo) && (a <= win_hi));
      end
   endgenerate

   assign all_ok = &ok_vec;

endmodule

// File: rtl/lcdf_fit_calc.sv
module lcdf_fit_calc #(
   parameter int AW    = 32,
   parameter int DIM_W = 10,
   parameter int SLACK = 2
) (
   input  logic [DIM_W-1:0] width_m1,
   input  logic [DIM_W-1:0] height_m1,
   input  logic [2:0]       lg_bpp,
   input  logic [AW-1:0]    data_ofs,
   input  logic [AW-1:0]    top,
   input  logic [AW-1:0]    bot,
   output logic [DIM_W+1:0] stride,
   output logic             fits
);
   localparam int DW = DIM_W + 1;
   localparam int PW = 2 * DW;
   localparam int SW = PW + 4;
   localparam int NW = AW + 2;

   logic [DW-1:0] w, h;
   logic [PW-1:0] px;
   logic [SW-1:0] bits_total;
   logic [DW+3:0] line_bits;
   logic [NW-1:0] need, room;

   initial begin
      assert (AW >= SW) else $error("address width too small for frame size");
      assert (SLACK >= 0) else $error("negative slack");
   end

   assign w          = DW'(width_m1) + DW'(1);
   assign h          = DW'(height_m1) + DW'(1);
   assign px         = PW'(w) * PW'(h);
   assign bits_total = SW'(px) << lg_bpp;
   assign line_bits  = (DW+4)'(w) << lg_bpp;
   assign stride     = (DIM_W+2)'(line_bits >> 3);

   assign need = NW'(data_ofs) + NW'(bits_total >> 3);
   assign room = NW'(bot - top) + NW'(SLACK);
   assign fits = (need <= room);

endmodule

// File: rtl/lcdf_seq.sv
module lcdf_seq
   import lcdf_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DIM_W     = 10,
   parameter int LONG_OFS  = 'h200,
   parameter int SHORT_OFS = 'h20,
   parameter int SLACK     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic [1:0]       pal_mode,
   input  logic             dual_buf,
   input  logic [1:0]       dma_ie,
   input  logic [AW-1:0]    buf0_top,
   input  logic [AW-1:0]    buf0_bot,
   input  logic [AW-1:0]    buf1_top,
   input  logic [AW-1:0]    buf1_bot,
   input  logic [AW-1:0]    win_lo,
   input  logic [AW-1:0]    win_hi,
   input  logic [DIM_W-1:0] width_m1,
   input  logic [DIM_W-1:0] height_m1,
   input  logic             sub_en,
   input  logic             sub_first_sel,
   input  logic [DIM_W-1:0] sub_val,
   input  logic             refresh,
   output logic             hdr_req,
   output logic [AW-1:0]    hdr_addr,
   input  logic             hdr_valid,
   input  logic [15:0]      hdr_data,
   output logic             lcd_enable,
   output logic             busy,
   output logic             frame_go,
   output logic [AW-1:0]    pix_addr,
   output logic [DIM_W+1:0] line_stride,
   output logic [4:0]       pix_bits,
   output logic [DIM_W-1:0] line_first,
   output logic [DIM_W:0]   line_total,
   output logic [2:0]       cond_set,
   output logic             dma_irq,
   output logic             sync_err
);
   localparam int NB         = 4;
   localparam logic [1:0] MODE_NOPAL = 2'd1;
   localparam logic [1:0] MODE_PIXONLY = 2'd2;

   initial begin
      assert (DIM_W >= 4 && DIM_W <= 12) else $error("DIM_W out of range");
      assert (AW >= 2 * DIM_W + 8) else $error("AW too small");
   end

   seq_state_e st;
   logic          en_q, idx_q, skip_q;
   logic [AW-1:0] base_q [2];
   logic [15:0]   hdr_q;
   logic          fault_q, fault_irq_q, se_q;

   logic          win_ok, supported, fits;
   logic [2:0]    lg_bpp;
   logic [4:0]    bits_dec;
   logic [AW-1:0] data_ofs, act_top, act_bot, act_base;
   logic [DIM_W+1:0] stride_c;
   logic          en_start, en_stop;

   // ---------------- start-up window check ----------------
   lcdf_win_check #(.AW(AW), .NB(NB)) u_win (
      .bounds  ({buf1_bot, buf1_top, buf0_bot, buf0_top}),
      .use_mask({dual_buf, dual_buf, 1'b1, 1'b1}),
      .win_lo  (win_lo),
      .win_hi  (win_hi),
      .all_ok  (win_ok)
   );

   // ---------------- header decode ----------------
   lcdf_hdr_decode #(.AW(AW), .LONG_OFS(LONG_OFS), .SHORT_OFS(SHORT_OFS)) u_dec (
      .hdr      (hdr_q),
      .no_hdr   (skip_q),
      .supported(supported),
      .lg_bpp   (lg_bpp),
      .pix_bits (bits_dec),
      .data_ofs (data_ofs)
   );

   // ---------------- frame size check ----------------
   assign act_top  = idx_q ? buf1_top : buf0_top;
   assign act_bot  = idx_q ? buf1_bot : buf0_bot;
   assign act_base = base_q[idx_q];

   lcdf_fit_calc #(.AW(AW), .DIM_W(DIM_W), .SLACK(SLACK)) u_fit (
      .width_m1 (width_m1),
      .height_m1(height_m1),
      .lg_bpp   (lg_bpp),
      .data_ofs (data_ofs),
      .top      (act_top),
      .bot      (act_bot),
      .stride   (stride_c),
      .fits     (fits)
   );

   assign en_start = en_wr && en_wdata && !en_q;
   assign en_stop  = en_wr && !en_wdata;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         en_q        <= 1'b0;
         idx_q       <= 1'b0;
         skip_q      <= 1'b0;
         base_q[0]   <= '0;
         base_q[1]   <= '0;
         hdr_q       <= '0;
         fault_q     <= 1'b0;
         fault_irq_q <= 1'b0;
         se_q        <= 1'b0;
         pix_addr    <= '0;
         line_stride <= '0;
         pix_bits    <= '0;
         line_first  <= '0;
         line_total  <= '0;
      end else begin
         fault_q     <= 1'b0;
         fault_irq_q <= 1'b0;
         se_q        <= 1'b0;

         if (en_start) begin
            if (win_ok) begin
               en_q      <= 1'b1;
               idx_q     <= 1'b0;
               base_q[0] <= buf0_top;
               base_q[1] <= buf1_top;
            end else begin
               fault_q     <= 1'b1;
               fault_irq_q <= dma_ie[1];
            end
         end else if (en_stop) begin
            en_q <= 1'b0;
         end

         case (st)
            ST_IDLE: begin
               if (refresh && en_q && pal_mode != MODE_NOPAL) begin
                  skip_q <= (pal_mode == MODE_PIXONLY);
                  st     <= (pal_mode == MODE_PIXONLY) ? ST_CHECK : ST_READ_HDR;
               end
            end
            ST_READ_HDR: begin
               if (hdr_valid) begin
                  hdr_q <= hdr_data;
                  st    <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!supported) begin
                  st <= ST_IDLE;
               end else if (!fits) begin
                  se_q <= 1'b1;
                  en_q <= 1'b0;
                  st   <= ST_IDLE;
               end else begin
                  pix_addr    <= act_base + data_ofs;
                  line_stride <= stride_c;
                  pix_bits    <= bits_dec;
                  if (sub_en && sub_first_sel) begin
                     line_first <= sub_val;
                     line_total <= (DIM_W+1)'(height_m1) + (DIM_W+1)'(1);
                  end else if (sub_en) begin
                     line_first <= '0;
                     line_total <= (DIM_W+1)'(sub_val);
                  end else begin
                     line_first <= '0;
                     line_total <= (DIM_W+1)'(height_m1) + (DIM_W+1)'(1);
                  end
                  st <= ST_ISSUE;
               end
            end
            ST_ISSUE: st <= ST_DONE;
            ST_DONE: begin
               if (dual_buf) idx_q <= !idx_q;
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign hdr_req    = (st == ST_READ_HDR);
   assign hdr_addr   = act_base;
   assign busy       = (st != ST_IDLE);
   assign frame_go   = (st == ST_ISSUE);
   assign lcd_enable = en_q;
   assign sync_err   = se_q;
   assign cond_set   = {fault_q, (st == ST_DONE) && idx_q, (st == ST_DONE) && !idx_q};
   assign dma_irq    = fault_irq_q || ((st == ST_DONE) && dma_ie[0]);

   // ---------------- assertions ----------------
   p_go_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |-> !sync_err);

   p_err_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> !lcd_enable);

   p_buf_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |=> ($countones(cond_set[1:0]) == 1));

   p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cond_set[2] |-> !lcd_enable);

   p_hdr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_req && !hdr_valid) |=> (hdr_req && $stable(hdr_addr)));

endmodule

// File: tb/tb_lcdf_seq.sv
module tb_lcdf_seq;
   localparam int AW = 32;
   localparam int DW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_wr = 0, en_wdata = 0;
   logic [1:0] pal_mode = 0;
   logic dual_buf = 0;
   logic [1:0] dma_ie = 0;
   logic [AW-1:0] buf0_top, buf0_bot, buf1_top, buf1_bot, win_lo, win_hi;
   logic [DW-1:0] width_m1 = 10'd63, height_m1 = 10'd31;
   logic sub_en = 0, sub_first_sel = 0;
   logic [DW-1:0] sub_val = 0;
   logic refresh = 0;
   logic hdr_req, hdr_valid = 0;
   logic [AW-1:0] hdr_addr;
   logic [15:0] hdr_data = 0;
   logic lcd_enable, busy, frame_go, dma_irq, sync_err;
   logic [AW-1:0] pix_addr;
   logic [DW+1:0] line_stride;
   logic [4:0] pix_bits;
   logic [DW-1:0] line_first;
   logic [DW:0] line_total;
   logic [2:0] cond_set;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   lcdf_seq dut (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
      .pal_mode(pal_mode), .dual_buf(dual_buf), .dma_ie(dma_ie),
      .buf0_top(buf0_top), .buf0_bot(buf0_bot), .buf1_top(buf1_top), .buf1_bot(buf1_bot),
      .win_lo(win_lo), .win_hi(win_hi), .width_m1(width_m1), .height_m1(height_m1),
      .sub_en(sub_en), .sub_first_sel(sub_first_sel), .sub_val(sub_val),
      .refresh(refresh), .hdr_req(hdr_req), .hdr_addr(hdr_addr),
      .hdr_valid(hdr_valid), .hdr_data(hdr_data), .lcd_enable(lcd_enable),
      .busy(busy), .frame_go(frame_go), .pix_addr(pix_addr),
      .line_stride(line_stride), .pix_bits(pix_bits), .line_first(line_first),
      .line_total(line_total), .cond_set(cond_set), .dma_irq(dma_irq),
      .sync_err(sync_err)
   );

   // captured results of one refresh
   int g_go, g_se, g_hdr_cycles, g_irq;
   logic [2:0] g_cond;
   logic [AW-1:0] g_haddr, g_pix;
   logic [DW+1:0] g_stride;
   logic [4:0] g_bits;
   logic [DW-1:0] g_first;
   logic [DW:0] g_total;
   logic [2:0] g_econd;
   logic g_eirq;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic write_en(input logic v);
      @(negedge clk);
      en_wr = 1; en_wdata = v;
      @(negedge clk);
      g_econd = cond_set; g_eirq = dma_irq;
      en_wr = 0; en_wdata = 0;
   endtask

   task automatic run_frame(input logic [15:0] hdr, input int lat);
      int wait_left;
      wait_left = lat;
      g_go = 0; g_se = 0; g_hdr_cycles = 0; g_irq = 0; g_cond = 0;
      g_haddr = '1; g_pix = '0; g_stride = '0; g_bits = '0; g_first = '0; g_total = '0;
      @(negedge clk);
      refresh = 1;
      for (int c = 0; c < 14; c++) begin
         @(negedge clk);
         refresh = 0;
         hdr_valid = 0;
         if (frame_go) begin
            g_go++; g_pix = pix_addr; g_stride = line_stride; g_bits = pix_bits;
            g_first = line_first; g_total = line_total;
         end
         if (sync_err) g_se++;
         if (dma_irq) g_irq++;
         g_cond = g_cond | cond_set;
         if (hdr_req) begin
            g_hdr_cycles++;
            if (g_haddr !== '1 && g_haddr !== hdr_addr)
               chk("R12", "hdr_addr stable", hdr_addr, g_haddr);
            g_haddr = hdr_addr;
            if (wait_left == 0) begin
               hdr_valid = 1; hdr_data = hdr;
            end else wait_left--;
         end
      end
   endtask

   task automatic set_defaults();
      buf0_top = 32'h1000_0000; buf0_bot = 32'h1001_0000;
      buf1_top = 32'h1002_0000; buf1_bot = 32'h1003_0000;
      win_lo = 32'h1000_0000; win_hi = 32'h1FFF_FFFF;
      width_m1 = 10'd63; height_m1 = 10'd31;
      pal_mode = 0; dual_buf = 0; dma_ie = 0; sub_en = 0; sub_first_sel = 0; sub_val = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R11", "reset enable", lcd_enable, 0);
      chk("R11", "reset busy", busy, 0);
      chk("R6", "reset frame_go", frame_go, 0);
      chk("R6", "reset cond_set", cond_set, 0);
   endtask

   task automatic t_depths();
      set_defaults();
      write_en(1);
      chk("R11", "enable after start", lcd_enable, 1);
      run_frame(16'h1000, 0);
      chk("R1", "2bpp bits", g_bits, 2);
      chk("R3", "2bpp short offset", g_pix, 32'h1000_0020);
      chk("R8", "2bpp stride", g_stride, 16);
      run_frame(16'h2abc, 0);
      chk("R1", "4bpp bits", g_bits, 4);
      chk("R8", "4bpp stride", g_stride, 32);
      run_frame(16'h3000, 0);
      chk("R1", "8bpp bits", g_bits, 8);
      chk("R3", "8bpp long offset", g_pix, 32'h1000_0200);
      chk("R8", "8bpp stride", g_stride, 64);
      chk("R12", "header address", g_haddr, 32'h1000_0000);
      run_frame(16'h7fff, 0);
      chk("R1", "code7 bits", g_bits, 16);
      chk("R8", "16bpp stride", g_stride, 128);
      chk("R6", "frame_go once", g_go, 1);
      chk("R6", "buffer0 done bit", g_cond, 3'b001);
      chk("R9", "no subpanel first", g_first, 0);
      chk("R9", "no subpanel total", g_total, 32);
   endtask

   task automatic t_unsupported();
      run_frame(16'h0fff, 0);
      chk("R2", "code0 no go", g_go, 0);
      chk("R2", "code0 no sync_err", g_se, 0);
      chk("R2", "code0 no cond", g_cond, 0);
      chk("R2", "code0 idle", busy, 0);
   endtask

   task automatic t_mode2();
      run_frame(16'h3000, 0);       // header now holds code 3
      pal_mode = 2;
      run_frame(16'h1000, 0);
      chk("R3", "mode2 no header read", g_hdr_cycles, 0);
      chk("R3", "mode2 zero offset", g_pix, 32'h1000_0000);
      chk("R3", "mode2 keeps last depth", g_bits, 8);
      pal_mode = 0;
   endtask

   task automatic t_ignored();
      pal_mode = 1;
      run_frame(16'h3000, 0);
      chk("R4", "mode1 no header", g_hdr_cycles, 0);
      chk("R4", "mode1 no go", g_go, 0);
      pal_mode = 0;
      write_en(0);
      run_frame(16'h3000, 0);
      chk("R4", "disabled no header", g_hdr_cycles, 0);
      chk("R4", "disabled no go", g_go, 0);
   endtask

   task automatic t_overflow();
      set_defaults();
      write_en(1);
      buf0_bot = buf0_top + 32'd2558;   // need 0x200+2048=2560 == size+2
      run_frame(16'h3000, 0);
      chk("R5", "exact fit accepted", g_go, 1);
      chk("R5", "exact fit no error", g_se, 0);
      buf0_bot = buf0_top + 32'd2557;
      run_frame(16'h3000, 0);
      chk("R5", "overflow sync_err", g_se, 1);
      chk("R5", "overflow no go", g_go, 0);
      chk("R5", "overflow disables", lcd_enable, 0);
      set_defaults();
   endtask

   task automatic t_dual();
      set_defaults();
      dual_buf = 1; dma_ie = 2'b01;
      write_en(1);
      run_frame(16'h3000, 0);
      chk("R6", "dual first addr", g_pix, 32'h1000_0200);
      chk("R6", "irq on done", g_irq, 1);
      run_frame(16'h3000, 0);
      chk("R7", "dual second addr", g_pix, 32'h1002_0200);
      chk("R6", "buffer1 done bit", g_cond, 3'b010);
      chk("R12", "header from buffer1", g_haddr, 32'h1002_0000);
      run_frame(16'h3000, 0);
      chk("R7", "dual wraps to buffer0", g_pix, 32'h1000_0200);
      write_en(1);                 // already enabled: index stays 1
      run_frame(16'h3000, 0);
      chk("R11", "rewrite keeps index", g_pix, 32'h1002_0200);
      write_en(0);
      set_defaults();
      write_en(1);
      run_frame(16'h3000, 0);
      run_frame(16'h3000, 0);
      chk("R7", "single stays buffer0", g_pix, 32'h1000_0200);
      chk("R6", "no irq when ie0 clear", g_irq, 0);
   endtask

   task automatic t_fault();
      write_en(0);
      set_defaults();
      buf0_bot = 32'h2000_0000;
      dma_ie = 2'b10;
      write_en(1);
      chk("R10", "fault cond bit", g_econd, 3'b100);
      chk("R10", "fault irq", g_eirq, 1);
      chk("R10", "fault keeps disabled", lcd_enable, 0);
      set_defaults();
      buf1_top = 32'h0000_0100;   // bad, but single mode
      write_en(1);
      chk("R10", "buf1 unchecked in single", lcd_enable, 1);
      chk("R10", "no fault single", g_econd, 0);
      write_en(0);
      dual_buf = 1;
      write_en(1);
      chk("R10", "buf1 checked in dual", g_econd, 3'b100);
      chk("R10", "no irq when ie1 clear", g_eirq, 0);
      set_defaults();
   endtask

   task automatic t_latch();
      write_en(0);
      set_defaults();
      write_en(1);
      buf0_top = 32'h1000_4000;
      buf0_bot = 32'h1001_4000;
      run_frame(16'h3000, 0);
      chk("R11", "base latched at start", g_pix, 32'h1000_0200);
      set_defaults();
   endtask

   task automatic t_subpanel();
      sub_en = 1; sub_first_sel = 1; sub_val = 10'd5;
      run_frame(16'h3000, 0);
      chk("R9", "first-line mode first", g_first, 5);
      chk("R9", "first-line mode total", g_total, 32);
      sub_first_sel = 0; sub_val = 10'd10;
      run_frame(16'h3000, 0);
      chk("R9", "total mode first", g_first, 0);
      chk("R9", "total mode total", g_total, 10);
      sub_en = 0;
   endtask

   task automatic t_latency();
      run_frame(16'h2000, 3);
      chk("R12", "req held while waiting", g_hdr_cycles, 4);
      chk("R12", "late header frame", g_go, 1);
      chk("R1", "late header depth", g_bits, 4);
   endtask

   initial begin
      set_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_depths();
      t_unsupported();
      t_mode2();
      t_ignored();
      t_overflow();
      t_dual();
      t_fault();
      t_latch();
      t_subpanel();
      t_latency();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule